// File: doc/BRIEF.md
# Pass-Through Burst Read Responder

This block sits on the add-on side of a host bus bridge. It serves host read requests that the bridge forwards through its pass-through port. When the bridge pulls its active-low attention line low and flags a read, the responder does four things in turn:

- It latches the region number and byte enables.
- It fetches the captured host address with a one-cycle address-register read strobe.
- It points its register select at the pass-through data register.
- It streams words from a local source into that register, one data phase per completing clock edge.

Read data moves from the add-on into the bridge through a write-strobed register. A data phase completes only on an edge where the write strobe, the ready strobe and attention are all low. The host inserts wait states by letting attention go high in the middle of a burst. While attention is high the pending word stays on the data bus. The responder can also slow the transfer down. A parameter sets a fixed gap of idle clocks after each word, and ready is held off whenever the local source has no word. A burst ends when the bridge releases the burst flag. An access for which the flag never goes low is a single data phase. After either kind of end, a hold-off period passes before a new access is accepted.

Top module: `pt_read_agent`

## Requirements
- R1: During and right after synchronous reset, `adr_rd_n`, `sel_n`, `wr_n` and `rdy_n` are high (deasserted) and `src_pop` is low.
- R2: An access starts on an edge where `attn_n` is 0 and `wr_dir` is 0 (0 = read). At that edge `region_in` and `be_in_n` are latched into `host_region` and `host_be_n`. Later changes on those inputs do not alter the latched values.
- R3: An access with `wr_dir` = 1 is ignored. `adr_rd_n` and `sel_n` stay high for as long as it is presented.
- R4: In the cycle after the start edge, `adr_rd_n` is low for exactly one cycle. In that same cycle `sel_n` is low, `reg_ofs` is 0x2C and `reg_be_n` is 0000 (full 32-bit word). `host_addr` takes the value of `bridge_rdata` at the edge that ends that cycle.
- R5: A data phase completes on a rising edge where `wr_n`, `rdy_n` and `attn_n` are all 0. `src_pop` is high for exactly such edges, and each one consumes one source word. Words reach the bridge in source order.
- R6: While `attn_n` is high in the middle of a burst, no word is consumed and `wdata` keeps driving the pending word.
- R7: With the source ready and `attn_n` low throughout, consecutive completions are GAP+1 edges apart. The default GAP is 1, which gives one word every other clock.
- R8: `rdy_n` stays high while `src_valid` is 0, and no word is consumed.
- R9: Once the burst flag `burst_n` has been seen low in a transfer, its return high ends the burst. From that point `rdy_n` is high and no further word is consumed.
- R10: If `burst_n` stays high through the transfer, the access ends after its first completing edge.
- R11: After a burst ends, a new start is taken no earlier than HOLD_CYC (default 2) edges after the edge at which the end was recognised.
- R12: With WR_HOLD = 1 (default), `wr_n` stays low for the whole data stage, including throttle gaps in which `rdy_n` is high. No word is consumed in those gaps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| attn_n | input | 1 | Active-low attention from the bridge |
| burst_n | input | 1 | Active-low burst flag from the bridge |
| wr_dir | input | 1 | Access direction, 0 = read |
| region_in | input | 2 | Region number of the access |
| be_in_n | input | 4 | Active-low byte enables of the access |
| bridge_rdata | input | 32 | Bridge read bus, carries the host address during the address read |
| adr_rd_n | output | 1 | Active-low address-register read strobe |
| sel_n | output | 1 | Active-low register select |
| reg_ofs | output | 8 | Register offset presented to the bridge |
| reg_be_n | output | 4 | Active-low byte enables for the register access |
| wr_n | output | 1 | Active-low write strobe |
| rdy_n | output | 1 | Active-low ready strobe |
| wdata | output | 32 | Data written into the pass-through data register |
| src_valid | input | 1 | Local source has a word |
| src_data | input | 32 | Local source word |
| src_pop | output | 1 | Word consumed at this edge |
| host_addr | output | 32 | Captured host address |
| host_region | output | 2 | Latched region number |
| host_be_n | output | 4 | Latched byte enables |

## Verification
The bench inserts host wait states in the middle of a burst. A responder that ignored attention would consume words while attention is high, or would let the pending word change. The bench releases the burst flag right after the last phase while source data is still available. A design that failed to gate ready on the released flag would push a stray extra word into the bridge. The bench also retries an access straight after a burst to catch a missing hold-off. It throttles the transfer and stalls the source to catch ready being asserted with no word or during a pacing gap. It presents write-direction accesses, which a faulty direction check would answer with strobes.

// File: rtl/pt_pkg.sv
package pt_pkg;

    localparam int PT_DW    = 32;
    localparam int PT_BE_W  = PT_DW / 8;
    localparam int PT_OFS_W = 8;

    // data register offset decoded by the bridge
    localparam logic [PT_OFS_W-1:0] PT_DATA_OFS = 8'h2C;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ADDR,
        ST_DATA,
        ST_HOLD
    } pt_state_e;

    typedef struct packed {
        logic [1:0]         region;
        logic [PT_BE_W-1:0] be_n;
    } pt_status_t;

    // a phase retires when all three low-active strobes meet at an edge
    function automatic logic phase_done(input logic wr_n, input logic rdy_n,
                                        input logic attn_n);
        return !wr_n && !rdy_n && !attn_n;
    endfunction

endpackage

// File: rtl/pt_status_capture.sv
module pt_status_capture
    import pt_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             take_status,
    input  pt_status_t       status_in,
    input  logic             take_addr,
    input  logic [PT_DW-1:0] addr_in,
    output pt_status_t       status_q,
    output logic [PT_DW-1:0] addr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            status_q <= '{region: 2'b00, be_n: '1};
            addr_q   <= '0;
        end else begin
            if (take_status) status_q <= status_in;
            if (take_addr)   addr_q   <= addr_in;
        end
    end

endmodule

// File: rtl/pt_pacer.sv
module pt_pacer #(
    parameter int GAP = 1
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic consumed,
    output logic open_slot
);

    generate
        if (GAP == 0) begin : g_free
            logic unused_in;
            assign unused_in = clk ^ rst ^ restart ^ consumed;
            assign open_slot = 1'b1;
        end else begin : g_gap
            localparam int GW = $clog2(GAP + 1);
            localparam logic [GW-1:0] GAP_V = GW'(GAP);
            logic [GW-1:0] cnt_q;

            always_ff @(posedge clk) begin
                if (rst || restart) begin
                    cnt_q <= '0;
                end else if (consumed) begin
                    cnt_q <= GAP_V;
                end else if (cnt_q != '0) begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end

            assign open_slot = (cnt_q == '0);
        end
    endgenerate

endmodule

// File: rtl/pt_ctrl.sv
module pt_ctrl
    import pt_pkg::*;
#(
    parameter int HOLD_CYC = 2,
    parameter bit WR_HOLD  = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic attn_n,
    input  logic burst_n,
    input  logic wr_dir,
    input  logic src_valid,
    input  logic pace_open,
    output logic start,
    output logic take_addr,
    output logic adr_rd_n,
    output logic sel_n,
    output logic drive_data,
    output logic wr_n,
    output logic rdy_n,
    output logic complete
);

    localparam int HW = $clog2(HOLD_CYC + 1);
    localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYC - 1);

    pt_state_e       state_q, state_d;
    logic            in_burst_q;
    logic [HW-1:0]   hold_q;
    logic            burst_seen, burst_over, rdy_ok, in_data;

    assign in_data    = (state_q == ST_DATA);
    assign burst_seen = in_burst_q || !burst_n;
    assign burst_over = in_burst_q && burst_n;
    assign rdy_ok     = in_data && !burst_over && src_valid && pace_open;

    assign start      = (state_q == ST_IDLE) && !attn_n && !wr_dir;
    assign take_addr  = (state_q == ST_ADDR);
    assign adr_rd_n   = !take_addr;
    assign sel_n      = !(take_addr || in_data);
    assign drive_data = in_data;
    assign rdy_n      = !rdy_ok;

    generate
        if (WR_HOLD) begin : g_wr_hold
            assign wr_n = !(in_data && !burst_over);
        end else begin : g_wr_follow
            assign wr_n = !rdy_ok;
        end
    endgenerate

    assign complete = phase_done(wr_n, rdy_n, attn_n);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (start) state_d = ST_ADDR;
            ST_ADDR: state_d = ST_DATA;
            ST_DATA: begin
                if (burst_over)                   state_d = ST_HOLD;
                else if (complete && !burst_seen) state_d = ST_HOLD;
            end
            ST_HOLD: if (hold_q == HOLD_LAST) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= ST_IDLE;
            in_burst_q <= 1'b0;
            hold_q     <= '0;
        end else begin
            state_q <= state_d;
            if (start)                   in_burst_q <= 1'b0;
            else if (in_data && !burst_n) in_burst_q <= 1'b1;
            if (state_q != ST_HOLD && state_d == ST_HOLD) hold_q <= HW'(1);
            else if (state_q == ST_HOLD)                  hold_q <= hold_q + 1'b1;
        end
    end

endmodule

// File: rtl/pt_read_agent.sv
module pt_read_agent
    import pt_pkg::*;
#(
    parameter int GAP      = 1,
    parameter int HOLD_CYC = 2,
    parameter bit WR_HOLD  = 1'b1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                attn_n,
    input  logic                burst_n,
    input  logic                wr_dir,
    input  logic [1:0]          region_in,
    input  logic [PT_BE_W-1:0]  be_in_n,
    input  logic [PT_DW-1:0]    bridge_rdata,
    output logic                adr_rd_n,
    output logic                sel_n,
    output logic [PT_OFS_W-1:0] reg_ofs,
    output logic [PT_BE_W-1:0]  reg_be_n,
    output logic                wr_n,
    output logic                rdy_n,
    output logic [PT_DW-1:0]    wdata,
    input  logic                src_valid,
    input  logic [PT_DW-1:0]    src_data,
    output logic                src_pop,
    output logic [PT_DW-1:0]    host_addr,
    output logic [1:0]          host_region,
    output logic [PT_BE_W-1:0]  host_be_n
);

    logic       start, take_addr, drive_data, complete, pace_open;
    pt_status_t status_in, status_q;

    assign status_in = '{region: region_in, be_n: be_in_n};

    pt_ctrl #(.HOLD_CYC(HOLD_CYC), .WR_HOLD(WR_HOLD)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .attn_n     (attn_n),
        .burst_n    (burst_n),
        .wr_dir     (wr_dir),
        .src_valid  (src_valid),
        .pace_open  (pace_open),
        .start      (start),
        .take_addr  (take_addr),
        .adr_rd_n   (adr_rd_n),
        .sel_n      (sel_n),
        .drive_data (drive_data),
        .wr_n       (wr_n),
        .rdy_n      (rdy_n),
        .complete   (complete)
    );

    pt_pacer #(.GAP(GAP)) u_pacer (
        .clk       (clk),
        .rst       (rst),
        .restart   (start),
        .consumed  (complete),
        .open_slot (pace_open)
    );

    pt_status_capture u_cap (
        .clk         (clk),
        .rst         (rst),
        .take_status (start),
        .status_in   (status_in),
        .take_addr   (take_addr),
        .addr_in     (bridge_rdata),
        .status_q    (status_q),
        .addr_q      (host_addr)
    );

    assign host_region = status_q.region;
    assign host_be_n   = status_q.be_n;
    assign reg_ofs     = sel_n ? '0 : PT_DATA_OFS;
    assign reg_be_n    = sel_n ? '1 : '0;
    assign wdata       = drive_data ? src_data : '0;
    assign src_pop     = complete;

endmodule

// File: rtl/pt_read_agent_chk.sv
module pt_read_agent_chk
    import pt_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                attn_n,
    input logic                adr_rd_n,
    input logic                sel_n,
    input logic [PT_OFS_W-1:0] reg_ofs,
    input logic                wr_n,
    input logic                rdy_n,
    input logic                src_valid,
    input logic                src_pop
);

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (adr_rd_n && sel_n && wr_n && rdy_n && !src_pop));

    assert_adr_one_cycle_R4: assert property (@(posedge clk) disable iff (rst)
        !adr_rd_n |=> adr_rd_n);

    assert_adr_targets_data_R4: assert property (@(posedge clk) disable iff (rst)
        !adr_rd_n |-> (!sel_n && reg_ofs == PT_DATA_OFS));

    assert_pop_on_phase_R5: assert property (@(posedge clk) disable iff (rst)
        src_pop |-> (!wr_n && !rdy_n && !attn_n));

    assert_no_pop_in_wait_R6: assert property (@(posedge clk) disable iff (rst)
        attn_n |-> !src_pop);

    assert_no_ready_empty_R8: assert property (@(posedge clk) disable iff (rst)
        !src_valid |-> rdy_n);

endmodule

bind pt_read_agent pt_read_agent_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .attn_n    (attn_n),
    .adr_rd_n  (adr_rd_n),
    .sel_n     (sel_n),
    .reg_ofs   (reg_ofs),
    .wr_n      (wr_n),
    .rdy_n     (rdy_n),
    .src_valid (src_valid),
    .src_pop   (src_pop)
);

// File: tb/pt_read_agent_test.sv
module pt_read_agent_test;
    import pt_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic attn_n = 1'b1, burst_n = 1'b1, wr_dir = 1'b0;
    logic [1:0] region_in = 2'b00;
    logic [3:0] be_in_n = 4'hF;
    logic [31:0] bridge_rdata = '0;
    logic adr_rd_n, sel_n, wr_n, rdy_n, src_pop, src_valid;
    logic [7:0] reg_ofs;
    logic [3:0] reg_be_n, host_be_n;
    logic [31:0] wdata, src_data, host_addr;
    logic [1:0] host_region;

    logic [31:0] src_mem [16];
    int src_idx = 0, src_len = 0;
    logic src_stall = 1'b0;
    logic [31:0] got [16];
    int got_n = 0;
    int checks = 0, errors = 0;
    bit finished = 0;

    assign src_valid = !src_stall && (src_idx < src_len);
    assign src_data  = src_mem[src_idx[3:0]];

    always #(CLK_PERIOD/2) clk = ~clk;

    pt_read_agent uut (
        .clk(clk), .rst(rst), .attn_n(attn_n), .burst_n(burst_n), .wr_dir(wr_dir),
        .region_in(region_in), .be_in_n(be_in_n), .bridge_rdata(bridge_rdata),
        .adr_rd_n(adr_rd_n), .sel_n(sel_n), .reg_ofs(reg_ofs), .reg_be_n(reg_be_n),
        .wr_n(wr_n), .rdy_n(rdy_n), .wdata(wdata), .src_valid(src_valid),
        .src_data(src_data), .src_pop(src_pop), .host_addr(host_addr),
        .host_region(host_region), .host_be_n(host_be_n)
    );

    // bridge side: record every completing edge seen at the ports
    always @(posedge clk) begin
        if (!rst && !wr_n && !rdy_n && !attn_n) begin
            got[got_n[3:0]] <= wdata;
            got_n <= got_n + 1;
        end
        if (!rst && src_pop) src_idx <= src_idx + 1;
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    task automatic t_reset();
        step(); step();
        chk(adr_rd_n && sel_n && wr_n && rdy_n && !src_pop, "R1 strobes in reset",
            {27'd0, adr_rd_n, sel_n, wr_n, rdy_n, src_pop}, 32'h1E);
        rst = 1'b0;
        step();
        chk(adr_rd_n && sel_n && wr_n && rdy_n, "R1 strobes after reset",
            {28'd0, adr_rd_n, sel_n, wr_n, rdy_n}, 32'hF);
    endtask

    task automatic t_single();
        src_mem[0] = 32'hA1A1_0001; src_len = 1;
        bridge_rdata = 32'h1234_5670;
        attn_n = 0; burst_n = 1; wr_dir = 0; region_in = 2'd2; be_in_n = 4'h0;
        step();
        chk(!adr_rd_n, "R4 address strobe low", {31'd0, adr_rd_n}, 0);
        chk(!sel_n && reg_ofs == 8'h2C && reg_be_n == 4'h0, "R4 data register targeted",
            {19'd0, sel_n, reg_be_n, reg_ofs}, 32'h2C);
        chk(host_region == 2'd2 && host_be_n == 4'h0, "R2 status latched",
            {26'd0, host_region, host_be_n}, 32'h20);
        region_in = 2'd1; be_in_n = 4'hA; bridge_rdata = 32'h1234_5670;
        step();
        bridge_rdata = 32'hDEAD_0000;
        chk(adr_rd_n, "R4 address strobe one cycle", {31'd0, adr_rd_n}, 1);
        chk(host_addr == 32'h1234_5670, "R4 host address captured", host_addr, 32'h1234_5670);
        chk(host_region == 2'd2 && host_be_n == 4'h0, "R2 status held",
            {26'd0, host_region, host_be_n}, 32'h20);
        chk(!rdy_n && !wr_n && wdata == 32'hA1A1_0001, "R5 first word offered", wdata, 32'hA1A1_0001);
        step();
        chk(got_n == 1 && got[0] == 32'hA1A1_0001, "R5 single word delivered", got[0], 32'hA1A1_0001);
        chk(rdy_n, "R10 single access ended", {31'd0, rdy_n}, 1);
        attn_n = 1;
        step(); step();
        chk(got_n == 1, "R10 no second phase", got_n, 1);
    endtask

    task automatic t_write_ignored();
        wr_dir = 1; attn_n = 0;
        for (int i = 0; i < 4; i++) begin
            step();
            chk(adr_rd_n && sel_n, "R3 write access ignored", {30'd0, adr_rd_n, sel_n}, 3);
        end
        attn_n = 1; wr_dir = 0;
        step();
    endtask

    task automatic t_burst_waits();
        int base;
        int k;
        bit was_wait;
        int pend;
        base = got_n;
        src_idx = 0; src_len = 6;
        for (int i = 0; i < 6; i++) src_mem[i] = 32'hB000_0000 + 32'(i * 17);
        bridge_rdata = 32'h0000_8800;
        attn_n = 0; burst_n = 0; wr_dir = 0; region_in = 2'd3; be_in_n = 4'h0;
        step(); step();
        k = 0;
        while (got_n - base < 6 && k < 60) begin
            attn_n = (k == 2 || k == 3 || k == 6 || k == 9) ? 1'b1 : 1'b0;
            was_wait = attn_n;
            pend = got_n;
            if (was_wait)
                chk(wdata == src_mem[(got_n - base) % 16], "R6 pending word held",
                    wdata, src_mem[(got_n - base) % 16]);
            step();
            if (was_wait) chk(got_n == pend, "R6 no word in wait state", got_n, pend);
            k++;
        end
        for (int i = 0; i < 6; i++)
            chk(got[(base + i) % 16] == src_mem[i], "R5 burst word order",
                got[(base + i) % 16], src_mem[i]);
        // bridge ends the burst and immediately retries a read
        src_mem[6] = 32'hC7C7_0007; src_len = 7;
        burst_n = 1; attn_n = 0;
        #1;
        chk(rdy_n, "R9 ready withheld at burst end", {31'd0, rdy_n}, 1);
        step();
        chk(got_n - base == 6, "R9 no extra word", got_n - base, 6);
        chk(adr_rd_n, "R11 hold-off first edge", {31'd0, adr_rd_n}, 1);
        step();
        chk(adr_rd_n, "R11 hold-off second edge", {31'd0, adr_rd_n}, 1);
        step();
        chk(!adr_rd_n, "R11 new access accepted", {31'd0, adr_rd_n}, 0);
        step(); step();
        chk(got_n - base == 7 && got[(base + 6) % 16] == 32'hC7C7_0007,
            "R10 retried single read", got[(base + 6) % 16], 32'hC7C7_0007);
        attn_n = 1;
        step(); step();
    endtask

    task automatic t_throttle_stall();
        int base;
        base = got_n;
        src_idx = 0; src_len = 4;
        for (int i = 0; i < 4; i++) src_mem[i] = 32'hD000_0010 + 32'(i);
        attn_n = 0; burst_n = 0; wr_dir = 0;
        step(); step();
        step();
        chk(got_n - base == 1, "R7 first word", got_n - base, 1);
        chk(!wr_n && rdy_n, "R12 write held through gap", {30'd0, wr_n, rdy_n}, 1);
        step();
        chk(got_n - base == 1, "R12 no word in gap", got_n - base, 1);
        step();
        chk(got_n - base == 2, "R7 one word per GAP+1 edges", got_n - base, 2);
        src_stall = 1;
        step(); step();
        chk(rdy_n, "R8 ready high with empty source", {31'd0, rdy_n}, 1);
        step();
        chk(got_n - base == 2, "R8 no word while stalled", got_n - base, 2);
        src_stall = 0;
        #1;
        chk(!rdy_n, "R8 ready after source refills", {31'd0, rdy_n}, 0);
        step();
        chk(got_n - base == 3, "R7 word after stall", got_n - base, 3);
        step(); step();
        chk(got_n - base == 4 && got[(base + 3) % 16] == 32'hD000_0013,
            "R7 last throttled word", got[(base + 3) % 16], 32'hD000_0013);
        burst_n = 1; attn_n = 1;
        step(); step(); step();
        chk(got_n - base == 4, "R9 nothing after throttled burst", got_n - base, 4);
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", checks, 0);
        finish_run();
    end

    initial begin
        t_reset();
        t_single();
        t_write_ignored();
        t_burst_waits();
        t_throttle_stall();
        finish_run();
    end

endmodule